// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic unit of a small 8-bit accumulator machine. Each cycle it takes the accumulator value, a second operand (a scratch register, a memory byte, an immediate or a port value), the current carry flag and an operation code. It returns the new result byte, four new status flag values and a per-flag write enable that the register file uses to update its status word.

The unit covers binary addition, carry propagation into the accumulator, increment, decrement (done by adding all-ones to the register operand), compare (operand minus accumulator, flags only), packed-BCD addition, the bitwise operations, complement, a pass-through for port input, and logical shifts by one or four places in either direction. A hold code leaves every flag untouched. The sign flag here is the inverse of result bit 7, so it reads 1 for a non-negative result. Outputs are registered, so a result appears one clock after its operands.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, `result_o`, `flags_o` and `flag_we_o` are all zero.
- R2: Every output reflects the inputs present at the previous rising clock edge (one-cycle latency).
- R3: ADD (A+B), ADDC (A+carry_i) and INC (A+1) give the low 8 bits of the sum; carry = carry out of bit 7, overflow = carry into bit 7 XOR carry out of bit 7, zero = result is 0, sign = NOT result bit 7.
- R4: DEC gives B+0xFF with the flags of R3 computed on that addition.
- R5: CMP computes B−A as B+~A+1 and sets all four flags from it by the R3 rules (carry 1 means no borrow), while `result_o` equals A.
- R6: DADD on valid packed BCD inputs gives the BCD digits of (A+B) mod 100; carry is 1 when the decimal sum exceeds 99; overflow is that of the binary sum A+B; zero and sign come from the BCD result.
- R7: AND, OR, XOR (with B) and COM (~A) clear overflow and carry and set zero and sign from the result.
- R8: PASS returns B with the flag rule of R7.
- R9: SHR1 and SHR4 shift A right filling with zeros, clear overflow and carry, force sign to 1 and set zero from the result.
- R10: SHL1 and SHL4 shift A left filling with zeros, clear overflow and carry and set zero and sign from the result.
- R11: For every code except HOLD, `flag_we_o` is 4'b1111; HOLD returns A with `flag_we_o` = 0 and `flags_o` = 0.
- R12: Flag bit positions in `flags_o` and `flag_we_o`: bit 0 sign, bit 1 carry, bit 2 zero, bit 3 overflow.
- R13: `op_i` codes: 0 ADD, 1 ADDC, 2 INC, 3 DEC, 4 CMP, 5 DADD, 6 AND, 7 OR, 8 XOR, 9 COM, 10 PASS, 11 SHR1, 12 SHL1, 13 SHR4, 14 SHL4, 15 HOLD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_i | input | 8 | Accumulator operand (A) |
| opnd_i | input | 8 | Second operand (B) |
| carry_i | input | 1 | Current carry flag |
| op_i | input | 4 | Operation code |
| result_o | output | 8 | Registered result |
| flags_o | output | 4 | Registered new flag values |
| flag_we_o | output | 4 | Registered per-flag update enable |

## Verification
Every result, flag and enable is due exactly one rising edge after its operands are applied, with no path that takes longer or shorter. The bench sets inputs on a falling edge, lets one rising edge pass, and compares all three outputs against its behavioural model on the next falling edge, so each vector is checked in the one cycle it is due. Directed corner vectors (signed overflow, carry out to zero, equal compare, BCD wrap past 99, shifts to zero) run before a long pseudo-random sweep over all codes.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DW = 8;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_INC  = 4'd2,
        OP_DEC  = 4'd3,
        OP_CMP  = 4'd4,
        OP_DADD = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_COM  = 4'd9,
        OP_PASS = 4'd10,
        OP_SHR1 = 4'd11,
        OP_SHL1 = 4'd12,
        OP_SHR4 = 4'd13,
        OP_SHL4 = 4'd14,
        OP_HOLD = 4'd15
    } alu_op_e;

    // bit 3 overflow, bit 2 zero, bit 1 carry, bit 0 sign
    typedef struct packed {
        logic ovf;
        logic zero;
        logic carry;
        logic sign;
    } alu_flags_t;

    typedef struct packed {
        logic [DW-1:0] res;
        alu_flags_t    flags;
        alu_flags_t    we;
    } alu_out_t;

endpackage

// File: rtl/acc_alu_add.sv
module acc_alu_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    logic [W:0]   full_sum;
    logic [W-1:0] low_sum;

    always_comb begin
        full_sum = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
        low_sum  = {1'b0, x_i[W-2:0]} + {1'b0, y_i[W-2:0]} + {{(W-1){1'b0}}, cin_i};
        sum_o    = full_sum[W-1:0];
        cout_o   = full_sum[W];
        ovf_o    = full_sum[W] ^ low_sum[W-1];
    end
endmodule

// File: rtl/acc_alu_bcd.sv
module acc_alu_bcd #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] sum_o,
    output logic         dcarry_o,
    output logic         bin_ovf_o
);
    localparam int ND = W / 4;

    logic [ND:0]  dc;
    logic [W-1:0] bin_sum;
    logic         bin_cout;

    assign dc[0] = 1'b0;

    for (genvar g = 0; g < ND; g++) begin : g_digit
        logic [4:0] raw;
        logic       adj;
        always_comb begin
            raw = {1'b0, x_i[4*g +: 4]} + {1'b0, y_i[4*g +: 4]} + {4'b0, dc[g]};
            adj = (raw > 5'd9);
            sum_o[4*g +: 4] = adj ? (raw[3:0] + 4'd6) : raw[3:0];
        end
        assign dc[g+1] = adj;
    end

    assign dcarry_o = dc[ND];

    // overflow of the plain binary sum
    acc_alu_add #(.W(W)) u_bin (
        .x_i    (x_i),
        .y_i    (y_i),
        .cin_i  (1'b0),
        .sum_o  (bin_sum),
        .cout_o (bin_cout),
        .ovf_o  (bin_ovf_o)
    );
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = x_i & y_i;
            OP_OR:   res_o = x_i | y_i;
            OP_XOR:  res_o = x_i ^ y_i;
            OP_COM:  res_o = ~x_i;
            OP_PASS: res_o = y_i;
            OP_SHR1: res_o = x_i >> 1;
            OP_SHL1: res_o = x_i << 1;
            OP_SHR4: res_o = x_i >> 4;
            OP_SHL4: res_o = x_i << 4;
            default: res_o = x_i;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] opnd_i,
    input  logic          carry_i,
    input  logic [3:0]    op_i,
    output logic [DW-1:0] result_o,
    output logic [3:0]    flags_o,
    output logic [3:0]    flag_we_o
);
    localparam int MSB = DW - 1;

    alu_op_e       op;
    logic [DW-1:0] add_x, add_y, add_sum;
    logic          add_cin, add_cout, add_ovf;
    logic [DW-1:0] bcd_sum, lg_res;
    logic          bcd_c, bcd_ovf;
    alu_out_t      nxt_d, out_q;

    assign op = alu_op_e'(op_i);

    // adder operand selection
    always_comb begin
        add_x   = acc_i;
        add_y   = opnd_i;
        add_cin = 1'b0;
        unique case (op)
            OP_ADDC: begin add_y = '0; add_cin = carry_i; end
            OP_INC:  begin add_y = '0; add_cin = 1'b1;    end
            OP_DEC:  begin add_x = opnd_i; add_y = '1;    end
            OP_CMP:  begin add_x = opnd_i; add_y = ~acc_i; add_cin = 1'b1; end
            default: ;
        endcase
    end

    acc_alu_add #(.W(DW)) u_add (
        .x_i    (add_x),
        .y_i    (add_y),
        .cin_i  (add_cin),
        .sum_o  (add_sum),
        .cout_o (add_cout),
        .ovf_o  (add_ovf)
    );

    acc_alu_bcd #(.W(DW)) u_bcd (
        .x_i       (acc_i),
        .y_i       (opnd_i),
        .sum_o     (bcd_sum),
        .dcarry_o  (bcd_c),
        .bin_ovf_o (bcd_ovf)
    );

    acc_alu_logic #(.W(DW)) u_logic (
        .op_i  (op),
        .x_i   (acc_i),
        .y_i   (opnd_i),
        .res_o (lg_res)
    );

    always_comb begin
        nxt_d    = '0;
        nxt_d.we = '{ovf: 1'b1, zero: 1'b1, carry: 1'b1, sign: 1'b1};
        unique case (op)
            OP_ADD, OP_ADDC, OP_INC, OP_DEC, OP_CMP: begin
                nxt_d.res         = (op == OP_CMP) ? acc_i : add_sum;
                nxt_d.flags.ovf   = add_ovf;
                nxt_d.flags.carry = add_cout;
                nxt_d.flags.zero  = (add_sum == '0);
                nxt_d.flags.sign  = ~add_sum[MSB];
            end
            OP_DADD: begin
                nxt_d.res         = bcd_sum;
                nxt_d.flags.ovf   = bcd_ovf;
                nxt_d.flags.carry = bcd_c;
                nxt_d.flags.zero  = (bcd_sum == '0);
                nxt_d.flags.sign  = ~bcd_sum[MSB];
            end
            OP_HOLD: begin
                nxt_d.res = acc_i;
                nxt_d.we  = '0;
            end
            default: begin
                nxt_d.res        = lg_res;
                nxt_d.flags.zero = (lg_res == '0);
                nxt_d.flags.sign = (op == OP_SHR1 || op == OP_SHR4) ? 1'b1 : ~lg_res[MSB];
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= nxt_d;
    end

    assign result_o  = out_q.res;
    assign flags_o   = out_q.flags;
    assign flag_we_o = out_q.we;

    p_shr_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SHR1 || op_i == OP_SHR4) |=> (flags_o[0] && !flags_o[1] && !flags_o[3]))
        else $error("right shift flag rule broken");

    p_logic_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i inside {OP_AND, OP_OR, OP_XOR, OP_COM, OP_PASS}) |=> (!flags_o[3] && !flags_o[1]))
        else $error("logic op left overflow or carry set");

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_HOLD) |=> (flag_we_o == 4'h0 && result_o == $past(acc_i)))
        else $error("hold changed flags or result");

    p_we_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_HOLD) |=> (flag_we_o == 4'hF))
        else $error("flag enables incomplete");

    p_cmp_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMP) |=> (result_o == $past(acc_i)))
        else $error("compare altered accumulator value");

    p_inc_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_INC && acc_i == 8'hFF) |=> (flags_o[1] && flags_o[2] && result_o == 8'h00))
        else $error("increment wrap wrong");
endmodule

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] acc_i = '0, opnd_i = '0;
    logic       carry_i = 1'b0;
    logic [3:0] op_i = 4'd15;
    logic [7:0] result_o;
    logic [3:0] flags_o, flag_we_o;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    acc_alu u_dut (
        .clk(clk), .rst_n(rst_n), .acc_i(acc_i), .opnd_i(opnd_i),
        .carry_i(carry_i), .op_i(op_i), .result_o(result_o),
        .flags_o(flags_o), .flag_we_o(flag_we_o)
    );

    function automatic string tag_of(int op);
        case (op)
            0, 1, 2: return "R3";
            3:       return "R4";
            4:       return "R5";
            5:       return "R6";
            6, 7, 8, 9: return "R7";
            10:      return "R8";
            11, 13:  return "R9";
            12, 14:  return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic int sx(int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    function automatic int bcd_val(int v);
        return (v / 16) * 10 + (v % 16);
    endfunction

    // model: returns {res[15:8], flags[7:4], we[3:0]}
    function automatic int model(int op, int a, int b, int c);
        int r, s, ss, fo, fz, fc, fsn, we, x, y, ci;
        we = 15; fo = 0; fc = 0;
        if (op <= 4) begin
            x = a; y = b; ci = 0;
            case (op)
                1: begin y = 0; ci = c; end
                2: begin y = 0; ci = 1; end
                3: begin x = b; y = 255; end
                4: begin x = b; y = (~a) & 255; ci = 1; end
                default: ;
            endcase
            s  = x + y + ci;
            ss = sx(x) + sx(y) + ci;
            r  = s & 255;
            fc = (s > 255);
            fo = (ss > 127 || ss < -128);
            fz = (r == 0);
            fsn = (r < 128);
            if (op == 4) r = a;
        end else if (op == 5) begin
            s  = bcd_val(a) + bcd_val(b);
            fc = (s > 99);
            s  = s % 100;
            r  = (s / 10) * 16 + (s % 10);
            ss = sx(a) + sx(b);
            fo = (ss > 127 || ss < -128);
            fz = (r == 0);
            fsn = (r < 128);
        end else if (op == 15) begin
            r = a; we = 0; fz = 0; fsn = 0;
        end else begin
            case (op)
                6: r = a & b;
                7: r = a | b;
                8: r = a ^ b;
                9: r = (~a) & 255;
                10: r = b;
                11: r = a >> 1;
                12: r = (a << 1) & 255;
                13: r = a >> 4;
                default: r = (a << 4) & 255;
            endcase
            fz = (r == 0);
            fsn = (op == 11 || op == 13) ? 1 : (r < 128);
        end
        // R12: bit0 sign, bit1 carry, bit2 zero, bit3 overflow
        return (r << 8) | (((fo << 3) | (fz << 2) | (fc << 1) | fsn) << 4) | we;
    endfunction

    task automatic apply(int op, int a, int b, int c);
        int e;
        @(negedge clk);
        op_i = op[3:0]; acc_i = a[7:0]; opnd_i = b[7:0]; carry_i = c[0];
        e = model(op, a, b, c);
        @(negedge clk);   // one rising edge passed: R2 latency
        vectors++;
        if (result_o !== e[15:8] || flag_we_o !== e[3:0]) begin
            misses++;
            $display("FAIL %s R2 op=%0d a=%h b=%h: result/we got %h/%h exp %h/%h",
                     tag_of(op), op, a, b, result_o, flag_we_o, e[15:8], e[3:0]);
        end
        vectors++;
        if (flags_o !== e[7:4]) begin
            misses++;
            $display("FAIL %s R12 op=%0d a=%h b=%h c=%0d: flags got %b exp %b",
                     tag_of(op), op, a, b, c, flags_o, e[7:4]);
        end
    endtask

    initial begin
        #200000000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        int a, b;
        repeat (3) @(negedge clk);
        vectors++;
        if (result_o !== 8'h00 || flags_o !== 4'h0 || flag_we_o !== 4'h0) begin
            misses++;
            $display("FAIL R1 reset: got %h %b %b exp 00 0000 0000", result_o, flags_o, flag_we_o);
        end
        rst_n = 1'b1;

        // directed corners, op codes per R13
        apply(0, 8'h7F, 8'h01, 0);  // R3 signed overflow
        apply(0, 8'hFF, 8'h01, 0);  // R3 carry, zero
        apply(1, 8'hFF, 8'h00, 1);  // R3 add carry wraps
        apply(1, 8'h10, 8'h00, 0);  // R3 carry clear
        apply(2, 8'h7F, 8'h00, 0);  // R3 increment overflow
        apply(2, 8'hFF, 8'h00, 0);  // R3 increment wrap
        apply(3, 8'h00, 8'h00, 0);  // R4 decrement of zero
        apply(3, 8'h00, 8'h80, 0);  // R4 decrement overflow
        apply(3, 8'h00, 8'h01, 0);  // R4 to zero
        apply(4, 8'h42, 8'h42, 0);  // R5 equal
        apply(4, 8'h43, 8'h42, 0);  // R5 borrow
        apply(4, 8'h01, 8'h80, 0);  // R5 signed overflow
        apply(5, 8'h99, 8'h01, 0);  // R6 wrap to 00 with carry
        apply(5, 8'h45, 8'h55, 0);  // R6 nibble carries
        apply(5, 8'h38, 8'h29, 0);  // R6 low digit adjust
        apply(5, 8'h00, 8'h00, 0);  // R6 zero
        apply(6, 8'hF0, 8'h0F, 1);  // R7 zero
        apply(9, 8'h7F, 8'h00, 1);  // R7 complement
        apply(10, 8'h00, 8'h80, 1); // R8 pass negative
        apply(11, 8'h01, 8'h00, 1); // R9 to zero
        apply(13, 8'hF0, 8'h00, 1); // R9 nibble shift
        apply(12, 8'h80, 8'h00, 1); // R10 bit lost
        apply(14, 8'h08, 8'h00, 1); // R10 to negative
        apply(15, 8'hA5, 8'h3C, 1); // R11 hold

        // sweep all codes
        for (int i = 0; i < 4000; i++) begin
            int op;
            op = i % 16;
            a = $urandom_range(0, 255);
            b = $urandom_range(0, 255);
            if (op == 5) begin
                a = $urandom_range(0, 9) * 16 + $urandom_range(0, 9);
                b = $urandom_range(0, 9) * 16 + $urandom_range(0, 9);
            end
            apply(op, a, b, $urandom_range(0, 1));
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule